// File: doc/BRIEF.md
# Multi-Input Wake-Up Interrupt Controller

This block watches a bank of asynchronous wake-up lines arranged as eight groups of eight. Each line is brought into the clock domain through a two-flop synchronizer. It is then checked against a condition chosen per line: a high or low level, a rising or falling edge, or either edge. When the condition holds, a sticky pending bit is set. Software clears pending bits by writing ones to a clear register, and it can read the live synchronized level of every line.

Each group asks for service while any of its pending bits is also interrupt-enabled. A small set of interrupt outputs then merges these group requests. Each output carries its own group-select mask, so several groups can share one interrupt line. All control goes through a simple synchronous register port: writes are captured on the clock edge and reads are combinational.

The register address has two fields. The upper four bits select the register kind and the lower three bits select the group, or the interrupt output for the group-select masks.

Top module: `wake_intc`

## Requirements
- R1: After reset, every register reads zero (kinds 0 to 8, all indices) and `irq_out` is zero. Kind codes: 0 detection type (1 = level, 0 = edge), 1 polarity, 2 either-edge, 3 input enable, 4 interrupt enable, 5 pending (read only), 6 clear (write-one, reads zero), 7 live level (read only), 8 group-select mask of interrupt output `idx`.
- R2: Kind 7 of group g returns the synchronized level of `wake_in[8*g+b]` in bit b. A change is visible after two clock edges.
- R3: Level type with polarity 0 sets pending while the line is high. A clear written while the line is still high leaves the bit set.
- R4: Level type with polarity 1 sets pending while the line is low.
- R5: Edge type with either-edge 0 sets pending on a rising edge when polarity is 0, and on a falling edge when polarity is 1. The opposite edge and a steady level set nothing.
- R6: Edge type with either-edge 1 sets pending on both rising and falling edges.
- R7: A line whose input enable is 0 never sets pending. Turning the enable on while an edge-type line is high makes a spurious rising edge, and pending is set.
- R8: Writing kind 6 clears exactly the pending bits written as one (0xFF clears the whole group). Writes to kind 5 have no effect on pending.
- R9: When a detection and a clear hit the same pending bit in the same cycle, the bit ends set.
- R10: Bit i of `irq_out` is the OR, over the groups selected in mask i, of the OR of (pending AND interrupt enable) of that group. For example, mask 0x09 merges groups 0 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | {kind[3:0], index[2:0]} |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| wake_in | input | 64 | Asynchronous wake lines, group g line b at bit 8*g+b |
| irq_out | output | 4 | Merged interrupt outputs |

## Verification
The two functions that can collide are a detection and a software clear landing on the same pending bit in one cycle. The bench raises a rising-edge line and counts the two synchronizer stages. It then times the clear write so that the write is captured on the edge where the detection is latched. The pending bit must still read one afterwards. A level-type line held active while it is cleared stresses the same collision for every cycle of the condition, and the bound checker confirms that any cycle carrying a detection leaves its bit set.

// File: rtl/wake_intc_pkg.sv
package wake_intc_pkg;
  typedef enum logic [3:0] {
    K_TYPE  = 4'd0,
    K_POL   = 4'd1,
    K_EITH  = 4'd2,
    K_INEN  = 4'd3,
    K_IREN  = 4'd4,
    K_PEND  = 4'd5,
    K_CLR   = 4'd6,
    K_LIVE  = 4'd7,
    K_GSEL  = 4'd8
  } reg_kind_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/wake_detect.sv
module wake_detect #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl,
  input  logic [LINES-1:0] inen,
  input  logic [LINES-1:0] is_level,
  input  logic [LINES-1:0] pol,
  input  logic [LINES-1:0] either,
  input  logic [LINES-1:0] clr,
  output logic [LINES-1:0] pend,
  output logic [LINES-1:0] set_hit
);
  // polarity 0: active high, polarity 1: active low
  function automatic logic [LINES-1:0] level_match(input logic [LINES-1:0] cur,
                                                   input logic [LINES-1:0] p);
    return cur ^ p;
  endfunction

  // any change qualifies when either is set, else the new value must match ~p
  function automatic logic [LINES-1:0] edge_match(input logic [LINES-1:0] cur,
                                                  input logic [LINES-1:0] prev,
                                                  input logic [LINES-1:0] p,
                                                  input logic [LINES-1:0] e);
    return (cur ^ prev) & (e | (cur ^ p));
  endfunction

  logic [LINES-1:0] gated;
  logic [LINES-1:0] gated_q;

  assign gated   = lvl & inen;
  assign set_hit = inen & ((is_level & level_match(lvl, pol)) |
                           (~is_level & edge_match(gated, gated_q, pol, either)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gated_q <= '0;
      pend    <= '0;
    end else begin
      gated_q <= gated;
      pend    <= (pend & ~clr) | set_hit;
    end
  end
endmodule

// File: rtl/wake_merge.sv
module wake_merge #(
  parameter int GROUPS = 8,
  parameter int LINES  = 8,
  parameter int IRQS   = 4
) (
  input  logic [GROUPS*LINES-1:0] pend_flat,
  input  logic [GROUPS*LINES-1:0] iren_flat,
  input  logic [IRQS*GROUPS-1:0]  gsel_flat,
  output logic [IRQS-1:0]         irq_out
);
  function automatic logic any_active(input logic [LINES-1:0] p,
                                      input logic [LINES-1:0] en);
    return |(p & en);
  endfunction

  logic [GROUPS-1:0] grp_req;

  for (genvar g = 0; g < GROUPS; g++) begin : g_req
    assign grp_req[g] = any_active(pend_flat[g*LINES +: LINES],
                                   iren_flat[g*LINES +: LINES]);
  end

  for (genvar i = 0; i < IRQS; i++) begin : g_irq
    assign irq_out[i] = |(grp_req & gsel_flat[i*GROUPS +: GROUPS]);
  end
endmodule

// File: rtl/wake_intc.sv
module wake_intc
  import wake_intc_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int LINES  = 8,
  parameter int IRQS   = 4,
  parameter int KIND_W = 4,
  localparam int IDX_W  = $clog2(GROUPS),
  localparam int ADDR_W = KIND_W + IDX_W,
  localparam int DATA_W = (LINES > GROUPS) ? LINES : GROUPS,
  localparam int TOTAL  = GROUPS * LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [TOTAL-1:0]  wake_in,
  output logic [IRQS-1:0]   irq_out
);
  reg_kind_e        kind;
  logic [IDX_W-1:0] idx;
  assign kind = reg_kind_e'(reg_addr[ADDR_W-1:IDX_W]);
  assign idx  = reg_addr[IDX_W-1:0];

  logic [TOTAL-1:0] live_flat;
  logic [TOTAL-1:0] pend_flat;
  logic [TOTAL-1:0] iren_flat;
  logic [TOTAL-1:0] inen_flat;
  logic [TOTAL-1:0] set_flat;
  logic [TOTAL-1:0] clr_flat;
  logic [IRQS*GROUPS-1:0] gsel_flat;

  logic [LINES-1:0]  type_a [GROUPS];
  logic [LINES-1:0]  pol_a  [GROUPS];
  logic [LINES-1:0]  eith_a [GROUPS];
  logic [LINES-1:0]  inen_a [GROUPS];
  logic [LINES-1:0]  iren_a [GROUPS];
  logic [GROUPS-1:0] gsel_a [GROUPS];

  wake_sync #(.W(TOTAL)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(wake_in), .sync_out(live_flat)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = reg_we && (idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        type_a[g] <= '0;
        pol_a[g]  <= '0;
        eith_a[g] <= '0;
        inen_a[g] <= '0;
        iren_a[g] <= '0;
      end else if (hit) begin
        case (kind)
          K_TYPE: type_a[g] <= reg_wdata[LINES-1:0];
          K_POL:  pol_a[g]  <= reg_wdata[LINES-1:0];
          K_EITH: eith_a[g] <= reg_wdata[LINES-1:0];
          K_INEN: inen_a[g] <= reg_wdata[LINES-1:0];
          K_IREN: iren_a[g] <= reg_wdata[LINES-1:0];
          default: ;
        endcase
      end
    end

    assign clr_flat[g*LINES +: LINES]  = (hit && kind == K_CLR) ? reg_wdata[LINES-1:0] : '0;
    assign iren_flat[g*LINES +: LINES] = iren_a[g];
    assign inen_flat[g*LINES +: LINES] = inen_a[g];

    wake_detect #(.LINES(LINES)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (live_flat[g*LINES +: LINES]),
      .inen    (inen_a[g]),
      .is_level(type_a[g]),
      .pol     (pol_a[g]),
      .either  (eith_a[g]),
      .clr     (clr_flat[g*LINES +: LINES]),
      .pend    (pend_flat[g*LINES +: LINES]),
      .set_hit (set_flat[g*LINES +: LINES])
    );

    if (g < IRQS) begin : g_sel
      always_ff @(posedge clk) begin
        if (!rst_n)                    gsel_a[g] <= '0;
        else if (hit && kind == K_GSEL) gsel_a[g] <= reg_wdata[GROUPS-1:0];
      end
      assign gsel_flat[g*GROUPS +: GROUPS] = gsel_a[g];
    end else begin : g_nosel
      assign gsel_a[g] = '0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (kind)
      K_TYPE: reg_rdata = DATA_W'(type_a[idx]);
      K_POL:  reg_rdata = DATA_W'(pol_a[idx]);
      K_EITH: reg_rdata = DATA_W'(eith_a[idx]);
      K_INEN: reg_rdata = DATA_W'(inen_a[idx]);
      K_IREN: reg_rdata = DATA_W'(iren_a[idx]);
      K_PEND: reg_rdata = DATA_W'(pend_flat[idx*LINES +: LINES]);
      K_LIVE: reg_rdata = DATA_W'(live_flat[idx*LINES +: LINES]);
      K_GSEL: reg_rdata = DATA_W'(gsel_a[idx]);
      default: reg_rdata = '0;
    endcase
  end

  wake_merge #(.GROUPS(GROUPS), .LINES(LINES), .IRQS(IRQS)) u_merge (
    .pend_flat(pend_flat),
    .iren_flat(iren_flat),
    .gsel_flat(gsel_flat),
    .irq_out  (irq_out)
  );
endmodule

// File: rtl/wake_intc_chk.sv
module wake_intc_chk #(
  parameter int TOTAL = 64,
  parameter int IRQS  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TOTAL-1:0] pend_flat,
  input logic [TOTAL-1:0] iren_flat,
  input logic [TOTAL-1:0] set_flat,
  input logic [TOTAL-1:0] clr_flat,
  input logic [IRQS-1:0]  irq_out
);
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pend_flat == '0 && irq_out == '0)); // R1

  AST_NO_UNCAUSED_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_flat & ~$past(pend_flat) & ~$past(set_flat)) == '0)); // R3

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flat != '0) |=> ((pend_flat & $past(clr_flat & ~set_flat)) == '0)); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flat != '0) |=> ((pend_flat & $past(set_flat)) == $past(set_flat))); // R9

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |-> ((pend_flat & iren_flat) != '0)); // R10
endmodule

bind wake_intc wake_intc_chk #(.TOTAL(GROUPS*LINES), .IRQS(IRQS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pend_flat(pend_flat),
  .iren_flat(iren_flat),
  .set_flat (set_flat),
  .clr_flat (clr_flat),
  .irq_out  (irq_out)
);

// File: tb/tb_wake_intc.sv
module tb_wake_intc;
  localparam int KT = 0, KP = 1, KE = 2, KI = 3, KR = 4, KPEND = 5, KC = 6, KL = 7, KG = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [63:0] wake = '0;
  logic [3:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wake_intc dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_in(wake), .irq_out(irq_out)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input int kind, input int idx, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {kind[3:0], idx[2:0]}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int kind, input int idx, output logic [7:0] d);
    @(negedge clk);
    reg_addr = {kind[3:0], idx[2:0]};
    #1 d = reg_rdata;
  endtask

  task automatic expect_reg(input int kind, input int idx, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rd(kind, idx, v);
    check(v === exp, tag, v, exp);
  endtask

  task automatic drive(input int bitpos, input logic v);
    @(negedge clk);
    wake[bitpos] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int k = 0; k <= KG; k++) begin
      for (int g = 0; g < 8; g++) begin
        logic [7:0] v;
        rd(k, g, v);
        check(v === 8'h00, "R1 reset register", v, 8'h00);
      end
    end
    check(irq_out === 4'h0, "R1 reset irq_out", {4'h0, irq_out}, 8'h00);
  endtask

  task automatic t_live;
    @(negedge clk); wake[19] = 1'b1;
    @(negedge clk);
    expect_reg(KL, 2, 8'h08, "R2 live level after two edges");
    expect_reg(KPEND, 2, 8'h00, "R2 live level sets no pending");
  endtask

  task automatic t_level_high;
    wr(KT, 0, 8'h01); wr(KI, 0, 8'h01);
    expect_reg(KPEND, 0, 8'h00, "R3 low line not pending");
    drive(0, 1'b1);
    expect_reg(KPEND, 0, 8'h01, "R3 high level pending");
    wr(KC, 0, 8'h01);
    expect_reg(KPEND, 0, 8'h01, "R3 clear while high re-sets");
    drive(0, 1'b0);
    wr(KC, 0, 8'hFF);
    expect_reg(KPEND, 0, 8'h00, "R3 clear after line low");
  endtask

  task automatic t_level_low;
    wr(KT, 1, 8'h04); wr(KP, 1, 8'h04); wr(KI, 1, 8'h04);
    repeat (3) @(negedge clk);
    expect_reg(KPEND, 1, 8'h04, "R4 low level pending");
    drive(10, 1'b1);
    wr(KC, 1, 8'h04);
    expect_reg(KPEND, 1, 8'h00, "R4 high line clears and stays clear");
  endtask

  task automatic t_edge;
    wr(KP, 3, 8'h04); wr(KI, 3, 8'h06);
    drive(25, 1'b1);
    expect_reg(KPEND, 3, 8'h02, "R5 rising edge pending");
    wr(KC, 3, 8'h02);
    expect_reg(KPEND, 3, 8'h00, "R5 steady high no re-set");
    drive(25, 1'b0);
    expect_reg(KPEND, 3, 8'h00, "R5 falling ignored on rising line");
    drive(26, 1'b1);
    expect_reg(KPEND, 3, 8'h00, "R5 rising ignored on falling line");
    drive(26, 1'b0);
    expect_reg(KPEND, 3, 8'h04, "R5 falling edge pending");
    wr(KC, 3, 8'hFF);
  endtask

  task automatic t_either;
    wr(KE, 4, 8'h20); wr(KI, 4, 8'h20);
    drive(37, 1'b1);
    expect_reg(KPEND, 4, 8'h20, "R6 either-edge on rise");
    wr(KC, 4, 8'h20);
    expect_reg(KPEND, 4, 8'h00, "R6 cleared");
    drive(37, 1'b0);
    expect_reg(KPEND, 4, 8'h20, "R6 either-edge on fall");
  endtask

  task automatic t_inen;
    wr(KT, 5, 8'h02);
    @(negedge clk); wake[40] = 1'b1; wake[41] = 1'b1;
    repeat (4) @(negedge clk);
    expect_reg(KPEND, 5, 8'h00, "R7 disabled lines never pend");
    wr(KI, 5, 8'h01);
    @(negedge clk);
    expect_reg(KPEND, 5, 8'h01, "R7 spurious edge on enable");
    wr(KC, 5, 8'h01);
    expect_reg(KPEND, 5, 8'h00, "R7 spurious bit cleared");
  endtask

  task automatic t_clear;
    wr(KE, 6, 8'h0F); wr(KI, 6, 8'h0F);
    @(negedge clk); wake[51:48] = 4'hF;
    repeat (4) @(negedge clk);
    expect_reg(KPEND, 6, 8'h0F, "R8 four lines pending");
    wr(KPEND, 6, 8'h00);
    expect_reg(KPEND, 6, 8'h0F, "R8 write to pending ignored");
    wr(KC, 6, 8'h05);
    expect_reg(KPEND, 6, 8'h0A, "R8 partial clear");
    expect_reg(KC, 6, 8'h00, "R8 clear register reads zero");
    wr(KC, 6, 8'hFF);
    expect_reg(KPEND, 6, 8'h00, "R8 full clear");
  endtask

  task automatic t_set_wins;
    wr(KI, 7, 8'h01);
    @(negedge clk); wake[56] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {4'(KC), 3'd7}; reg_wdata = 8'h01;
    @(negedge clk);
    reg_we = 1'b0;
    expect_reg(KPEND, 7, 8'h01, "R9 detection beats same-cycle clear");
  endtask

  task automatic t_irq;
    wr(KT, 2, 8'h40); wr(KI, 2, 8'h40);
    drive(22, 1'b1);
    check(irq_out === 4'h0, "R10 no enable no irq", {4'h0, irq_out}, 8'h00);
    wr(KG, 1, 8'h04);
    wr(KR, 2, 8'h01);
    #1 check(irq_out === 4'h0, "R10 enable on other line", {4'h0, irq_out}, 8'h00);
    wr(KR, 2, 8'h40);
    #1 check(irq_out === 4'h2, "R10 group 2 on irq 1", {4'h0, irq_out}, 8'h02);
    wr(KT, 3, 8'h80); wr(KI, 3, 8'h86);
    drive(31, 1'b1);
    wr(KR, 3, 8'h80);
    wr(KG, 0, 8'h09);
    #1 check(irq_out === 4'h3, "R10 mask 0x09 merges group 3", {4'h0, irq_out}, 8'h03);
    wr(KG, 0, 8'h02);
    #1 check(irq_out === 4'h2, "R10 mask without requesting group", {4'h0, irq_out}, 8'h02);
    expect_reg(KG, 0, 8'h02, "R10 mask readback");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_live();
    t_level_high();
    t_level_low();
    t_edge();
    t_either();
    t_inen();
    t_clear();
    t_set_wins();
    t_irq();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule